// File: doc/BRIEF.md
# Masked Interrupt Flag Controller

This block gathers event strobes from a radio receiver core into a register of sticky interrupt flags. Each flag has a mask bit. An unmasked set flag drives a single active-low interrupt line toward a host processor. The host reads the flags inside a read window that it marks with begin and end strobes. When the window closes, the flags that the read reported are cleared.

An event that arrives while a read window is open is not lost. It is held in a per-bit pending store and written into the flag register when the window closes. Once the interrupt line has gone low, it is held low until the host finishes a flag read or writes the mask register. This stops a stream of later events from producing fresh interrupt edges. The serial bus slave that produces the strobes and the logic that produces the events are outside this block.

Top module: `irq_flag_ctrl`

## Requirements
- R1: An event input that is high in a cycle with no read window open sets its flag at the next clock edge. The flag then stays at 1 after the event goes low.
- R2: A mask write loads `maskWrData` into the mask register at the next edge. Reset clears every mask bit and every flag bit to 0.
- R3: A set flag whose mask bit is 0 leaves `irqN` high.
- R4: `irqN` is active low. It falls one clock after an unmasked set flag is present in the flag register, provided the line is not already latched low.
- R5: The read window opens at the edge that samples `rdBegin` high. It stays open up to and including the cycle where `rdEnd` is sampled high. While the window is open, the flag register does not change, and events are recorded in a pending store.
- R6: At the edge that closes the window, every flag that was set when `rdBegin` was sampled is cleared. At the same edge, the pending events are written into the flags. Flags set after the snapshot are kept.
- R7: An event still high in the cycle where the window closes leaves its flag set after the read.
- R8: Once `irqN` is low, it stays low, whatever later flags are set, until a read window closes or a mask write occurs. Either of those drives `irqN` high at the next edge. One edge later, the line follows the unmasked flags again.
- R9: `rdBegin` while a window is already open is ignored. `rdEnd` while no window is open is ignored, and flags keep their value.
- R10: An event held high through reset sets its flag at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evtIn | input | NUM_FLAGS | Event conditions, one per flag, active high |
| maskWrEn | input | 1 | Mask register write strobe |
| maskWrData | input | NUM_FLAGS | Value to load into the mask register |
| rdBegin | input | 1 | Host flag read starts (snapshot taken) |
| rdEnd | input | 1 | Host flag read finishes (reported flags cleared) |
| flagOut | output | NUM_FLAGS | Current flag register |
| maskOut | output | NUM_FLAGS | Current mask register |
| irqN | output | 1 | Interrupt line to the host, active low |

## Verification
Directed sequences cover several cases:
- events with the mask at zero against the mask at one, which separates flag setting from line assertion;
- events landing before, inside and on the closing cycle of a read window, which separates immediate, deferred and re-set behaviour;
- repeated mask writes while a request persists, which exposes the one-cycle release of a latched line.

After these, a long stretch of sparse random events, mask writes and stray or overlapping window strobes is run against a behavioural reference model. The model is compared every cycle, so any mismatch in snapshot, pending or latching order shows up in `flagOut`, `maskOut` or `irqN`.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic snapTake;  // read window opens this cycle: capture reported flags
    logic readDone;  // read window closes this cycle: clear reported, apply pending
    logic holdEvt;   // window open and not closing: park events as pending
    logic maskLoad;  // load new mask value
  } flagCtlS;

endpackage

// File: rtl/ifc_datapath.sv
module ifc_datapath
  import irq_flag_pkg::*;
#(
  parameter int NUM_FLAGS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  flagCtlS              ctl,
  input  logic [NUM_FLAGS-1:0] evtIn,
  input  logic [NUM_FLAGS-1:0] maskWrData,
  output logic [NUM_FLAGS-1:0] flagQ,
  output logic [NUM_FLAGS-1:0] maskQ,
  output logic                 anyReq
);

  logic [NUM_FLAGS-1:0] pendQ;
  logic [NUM_FLAGS-1:0] snapQ;

  // One cell per flag bit: flag, pending and snapshot storage.
  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : gFlag
    logic flagNext;
    logic pendNext;
    logic snapNext;

    always_comb begin
      flagNext = flagQ[gi];
      pendNext = pendQ[gi];
      snapNext = snapQ[gi];
      if (ctl.readDone) begin
        flagNext = (flagQ[gi] & ~snapQ[gi]) | pendQ[gi] | evtIn[gi];
        pendNext = 1'b0;
        snapNext = 1'b0;
      end else if (ctl.holdEvt) begin
        pendNext = pendQ[gi] | evtIn[gi];
      end else begin
        flagNext = flagQ[gi] | evtIn[gi];
        if (ctl.snapTake) begin
          snapNext = flagQ[gi];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flagQ[gi] <= 1'b0;
        pendQ[gi] <= 1'b0;
        snapQ[gi] <= 1'b0;
      end else begin
        flagQ[gi] <= flagNext;
        pendQ[gi] <= pendNext;
        snapQ[gi] <= snapNext;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskQ <= '0;
    end else if (ctl.maskLoad) begin
      maskQ <= maskWrData;
    end
  end

  assign anyReq = |(flagQ & maskQ);

  // Flags only fall at the edge that closes a read window.
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.readDone |=> ((flagQ & $past(flagQ)) == $past(flagQ))); // R1

  // Flag register frozen while a window is open and not closing.
  AST_WINDOW_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.holdEvt |=> $stable(flagQ)); // R5

  // Mask changes only on a mask write.
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.maskLoad |=> $stable(maskQ)); // R2

  // An event held into the closing cycle leaves its flag set.
  AST_HELD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.readDone |=> ((flagQ & $past(evtIn)) == $past(evtIn))); // R7

endmodule

// File: rtl/ifc_ctrl.sv
module ifc_ctrl
  import irq_flag_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rdBegin,
  input  logic    rdEnd,
  input  logic    maskWrEn,
  input  logic    anyReq,
  output flagCtlS ctl,
  output logic    irqN
);

  logic winQ;
  logic irqLatchQ;
  logic releaseNow;

  always_comb begin
    ctl.snapTake = !winQ && rdBegin;
    ctl.readDone = winQ && rdEnd;
    ctl.holdEvt  = winQ && !rdEnd;
    ctl.maskLoad = maskWrEn;
  end

  assign releaseNow = ctl.readDone || maskWrEn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winQ <= 1'b0;
    end else if (ctl.snapTake) begin
      winQ <= 1'b1;
    end else if (ctl.readDone) begin
      winQ <= 1'b0;
    end
  end

  // Latched interrupt: once asserted it holds until released.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqLatchQ <= 1'b0;
    end else if (releaseNow) begin
      irqLatchQ <= 1'b0;
    end else if (!irqLatchQ) begin
      irqLatchQ <= anyReq;
    end
  end

  assign irqN = !irqLatchQ;

  AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irqLatchQ && !releaseNow) |=> irqLatchQ); // R8

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqLatchQ) |-> $past(anyReq)); // R4

  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    releaseNow |=> irqN); // R8

  AST_STRAY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!winQ && !rdBegin) |=> !winQ); // R9

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int NUM_FLAGS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] evtIn,
  input  logic                 maskWrEn,
  input  logic [NUM_FLAGS-1:0] maskWrData,
  input  logic                 rdBegin,
  input  logic                 rdEnd,
  output logic [NUM_FLAGS-1:0] flagOut,
  output logic [NUM_FLAGS-1:0] maskOut,
  output logic                 irqN
);

  flagCtlS ctlS;
  logic    anyReq;

  ifc_ctrl uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdBegin  (rdBegin),
    .rdEnd    (rdEnd),
    .maskWrEn (maskWrEn),
    .anyReq   (anyReq),
    .ctl      (ctlS),
    .irqN     (irqN)
  );

  ifc_datapath #(.NUM_FLAGS(NUM_FLAGS)) uData (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctlS),
    .evtIn      (evtIn),
    .maskWrData (maskWrData),
    .flagQ      (flagOut),
    .maskQ      (maskOut),
    .anyReq     (anyReq)
  );

  // A masked-out flag alone never pulls the line low.
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irqN && ((flagOut & maskOut) == '0) && !maskWrEn) |=> irqN); // R3

endmodule

// File: tb/sim_irq_flag_ctrl.sv
`timescale 1ns/1ps
module sim_irq_flag_ctrl;
  localparam int NF = 8;
  localparam int LIMIT = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NF-1:0] evtIn = '0;
  logic          maskWrEn = 1'b0;
  logic [NF-1:0] maskWrData = '0;
  logic          rdBegin = 1'b0;
  logic          rdEnd = 1'b0;
  logic [NF-1:0] flagOut;
  logic [NF-1:0] maskOut;
  logic          irqN;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_flag_ctrl #(.NUM_FLAGS(NF)) u0 (
    .clk(clk), .rst_n(rst_n), .evtIn(evtIn), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .rdBegin(rdBegin), .rdEnd(rdEnd),
    .flagOut(flagOut), .maskOut(maskOut), .irqN(irqN)
  );

  // Behavioural reference model, updated at every rising edge.
  int mFlag[NF];
  int mPend[NF];
  int mSnap[NF];
  int mMask[NF];
  int mOpen = 0;
  int mLine = 0;  // 1 = line asserted (low)

  initial begin
    for (int i = 0; i < NF; i++) begin
      mFlag[i] = 0; mPend[i] = 0; mSnap[i] = 0; mMask[i] = 0;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) begin
        mFlag[i] = 0; mPend[i] = 0; mSnap[i] = 0; mMask[i] = 0;
      end
      mOpen = 0;
      mLine = 0;
    end else begin
      int want;
      int closing;
      want = 0;
      for (int i = 0; i < NF; i++) if (mFlag[i] != 0 && mMask[i] != 0) want = 1;
      closing = (mOpen != 0 && rdEnd) ? 1 : 0;
      if (closing != 0 || maskWrEn) mLine = 0;
      else if (mLine == 0) mLine = want;
      for (int i = 0; i < NF; i++) begin
        if (mOpen == 0) begin
          if (rdBegin) mSnap[i] = mFlag[i];
          if (evtIn[i]) mFlag[i] = 1;
        end else if (closing != 0) begin
          if (mSnap[i] != 0) mFlag[i] = 0;
          if (mPend[i] != 0 || evtIn[i]) mFlag[i] = 1;
          mPend[i] = 0;
          mSnap[i] = 0;
        end else if (evtIn[i]) begin
          mPend[i] = 1;
        end
        if (maskWrEn) mMask[i] = maskWrData[i] ? 1 : 0;
      end
      if (mOpen == 0 && rdBegin) mOpen = 1;
      else if (closing != 0) mOpen = 0;
    end
  end

  function automatic logic [NF-1:0] packInts(input int v[NF]);
    logic [NF-1:0] r;
    for (int i = 0; i < NF; i++) r[i] = (v[i] != 0);
    return r;
  endfunction

  // Model comparison on every falling edge.
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (flagOut !== packInts(mFlag)) begin
        errors++;
        $display("FAIL R1 model flags actual %h expected %h t=%0t", flagOut, packInts(mFlag), $time);
      end
      checks++;
      if (maskOut !== packInts(mMask)) begin
        errors++;
        $display("FAIL R2 model mask actual %h expected %h t=%0t", maskOut, packInts(mMask), $time);
      end
      checks++;
      if (irqN !== (mLine == 0)) begin
        errors++;
        $display("FAIL R4 model irqN actual %b expected %b t=%0t", irqN, (mLine == 0), $time);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [NF-1:0] act, input logic [NF-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual %0d expected below %0d", cycles, LIMIT);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10 / R2: event held through reset
    evtIn = 8'h04;
    tick(); tick();
    chk("R2 reset flags", flagOut, 8'h00);
    chk("R2 reset mask", maskOut, 8'h00);
    chk("R4 reset irqN", {7'b0, irqN}, 8'h01);
    rst_n = 1'b1;
    tick();
    evtIn = '0;
    chk("R10 held event after reset", flagOut, 8'h04);
    chk("R3 masked flag quiet", {7'b0, irqN}, 8'h01);

    // R1 / R3
    evtIn = 8'h01; tick(); evtIn = '0;
    chk("R1 event sets flag", flagOut, 8'h05);
    tick();
    chk("R1 flag sticky", flagOut, 8'h05);
    chk("R3 mask zero no line", {7'b0, irqN}, 8'h01);

    // R2 / R4
    maskWrEn = 1'b1; maskWrData = 8'h01; tick(); maskWrEn = 1'b0;
    chk("R2 mask loaded", maskOut, 8'h01);
    chk("R4 line not yet low", {7'b0, irqN}, 8'h01);
    tick();
    chk("R4 line low", {7'b0, irqN}, 8'h00);

    // R8: further event keeps line low
    evtIn = 8'h08; tick(); evtIn = '0;
    chk("R8 flag added while latched", flagOut, 8'h0D);
    chk("R8 line still low", {7'b0, irqN}, 8'h00);

    // R5 / R6: read with an event inside the window
    rdBegin = 1'b1; tick(); rdBegin = 1'b0;
    evtIn = 8'h20; tick(); evtIn = '0;
    chk("R5 flags frozen in window", flagOut, 8'h0D);
    evtIn = 8'h40; rdEnd = 1'b1; tick(); rdEnd = 1'b0; evtIn = '0;
    chk("R6 reported cleared, deferred applied", flagOut, 8'h60);
    chk("R8 line released by read", {7'b0, irqN}, 8'h01);
    tick();
    chk("R4 no unmasked flag", {7'b0, irqN}, 8'h01);

    // R7: condition present throughout a read
    evtIn = 8'h02; tick();
    rdBegin = 1'b1; tick(); rdBegin = 1'b0;
    rdEnd = 1'b1; tick(); rdEnd = 1'b0;
    chk("R7 held event re-sets flag", flagOut, 8'h02);
    evtIn = '0;

    // R9: stray end ignored, events still immediate
    rdEnd = 1'b1; tick(); rdEnd = 1'b0;
    chk("R9 stray end ignored", flagOut, 8'h02);
    evtIn = 8'h10; tick(); evtIn = '0;
    chk("R9 window still closed", flagOut, 8'h12);

    // R9: second begin inside open window ignored
    rdBegin = 1'b1; tick();
    evtIn = 8'h80; tick(); evtIn = '0; rdBegin = 1'b0;
    chk("R9 repeated begin ignored", flagOut, 8'h12);
    rdEnd = 1'b1; tick(); rdEnd = 1'b0;
    chk("R6 snapshot from first begin", flagOut, 8'h80);

    // R8: mask write release with persisting request
    maskWrEn = 1'b1; maskWrData = 8'h80; tick(); maskWrEn = 1'b0;
    chk("R8 irqN high on mask write", {7'b0, irqN}, 8'h01);
    tick();
    chk("R4 line low from flag 7", {7'b0, irqN}, 8'h00);
    maskWrEn = 1'b1; tick(); maskWrEn = 1'b0;
    chk("R8 one-cycle release", {7'b0, irqN}, 8'h01);
    tick();
    chk("R8 re-asserted", {7'b0, irqN}, 8'h00);

    // Random phase against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      evtIn = (r < 30) ? NF'($urandom) & NF'($urandom) : '0;
      maskWrEn = ($urandom_range(0, 19) == 0);
      maskWrData = NF'($urandom);
      rdBegin = ($urandom_range(0, 11) == 0);
      rdEnd = ($urandom_range(0, 7) == 0);
      tick();
    end
    evtIn = '0; maskWrEn = 1'b0; rdBegin = 1'b0; rdEnd = 1'b0;
    tick();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule